// File: doc/BRIEF.md
# Double-Buffered CAN Receive Store

This block keeps received CAN messages in two storage banks that change roles. At any moment one bank belongs to the host CPU, which reads it by byte index. The other bank is filled byte by byte by the protocol sequencer while a frame arrives on the bus. A new frame can therefore be captured while the CPU is still working through the previous message.

Each bank holds ten bytes in a fixed layout: index 0 is the identifier, index 1 is the control field, and indices 2 to 9 hold up to eight data bytes. The sequencer opens a frame with a start strobe and writes bytes only while the acceptance filter reports a pass. It then ends the frame with either a good-end strobe, which commits the message, or an abort strobe, which throws it away.

A committed message is handed to the CPU at once if the CPU bank is free. If the CPU is still busy, the message is parked in the write bank and handed over when the CPU releases its bank. If a further message completes while one is already parked, that message is dropped and a sticky overrun flag is raised.

Top module: `can_rx_dualbuf`

## Requirements
- R1: After reset, msg_valid and overrun are 0, bank 0 is the write bank, both banks read as zero, and nothing is parked.
- R2: A good-end strobe for an open, accepted frame, with msg_valid at 0 and nothing parked, swaps the banks. From the next cycle msg_valid is 1 and cpu_rdata at indices 0..9 returns the bytes written during that frame.
- R3: While rx_accept is 0, byte writes leave the write bank unchanged, and a good-end strobe commits nothing.
- R4: An abort strobe ends the frame without a swap and without setting msg_valid. The CPU bank contents stay unchanged.
- R5: While msg_valid is 1, a commit does not swap. The message is parked, and msg_valid and the CPU bank contents stay unchanged until the CPU releases.
- R6: cpu_release while msg_valid is 1 clears msg_valid on the next cycle. If a message is parked, one cycle later the banks swap, msg_valid returns to 1 and the parked bytes become readable.
- R7: A commit while a message is parked drops the new frame and sets overrun, which then stays set. The parked bank is not written while it is parked.
- R8: cpu_ovr_clear clears overrun on the next cycle. A drop in the same cycle takes priority and keeps overrun set.
- R9: cpu_idx values of 10 to 15 read as 0. rx_byte_we with rx_byte_idx of 10 to 15 changes no byte.
- R10: Byte writes are accepted only between a start strobe and the next good-end or abort strobe. A start in the same cycle as an end reopens the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame strobe from the sequencer |
| rx_accept | input | 1 | Acceptance filter pass level for the frame in progress |
| rx_byte_we | input | 1 | Byte write strobe |
| rx_byte_idx | input | 4 | Byte index within the write bank |
| rx_byte | input | 8 | Byte value to store |
| rx_eof_ok | input | 1 | Frame ended correctly; commit strobe |
| rx_abort | input | 1 | Frame aborted (error or lost arbitration) |
| cpu_idx | input | 4 | CPU read byte index |
| cpu_rdata | output | 8 | Byte at cpu_idx in the CPU bank (combinational) |
| cpu_release | input | 1 | CPU hands its bank back |
| cpu_ovr_clear | input | 1 | Clears the overrun flag |
| msg_valid | output | 1 | CPU bank holds an unread message |
| overrun | output | 1 | Sticky flag: a message was dropped |

## Verification
Several rules are checked every cycle: msg_valid holds until a release, overrun is sticky until cleared, out-of-range reads give zero, an abort never raises msg_valid, and msg_valid rises only after a commit or a parked handover. Other behaviour only shows up in the bench's scenarios. This covers byte contents surviving a swap, rejected or out-of-frame writes leaving the banks untouched, and the ordering when a parked message is handed over after a release. The same applies to overlaps such as a commit in the release cycle.

// File: rtl/can_rxbuf_pkg.sv
// Package: shared sizes and the commit decision encoding for the
// double-buffered receive store. Assumes a single clock domain.
package can_rxbuf_pkg;
    localparam int RXB_BYTES  = 10;
    localparam int RXB_DATA_W = 8;
    localparam int RXB_IDX_W  = 4;
    localparam int RXB_BANKS  = 2;

    // Outcome of a frame commit request
    typedef enum logic [1:0] {
        CM_NONE = 2'd0,   // no commit this cycle
        CM_SWAP = 2'd1,   // CPU free: hand the write bank over now
        CM_PARK = 2'd2,   // CPU busy: keep the message in the write bank
        CM_DROP = 2'd3    // a message is already parked: overrun
    } commit_act_e;
endpackage

// File: rtl/rxbuf_bank.sv
// Module: one receive bank of NB bytes. Synchronous write of one byte
// per cycle, combinational read. Out-of-range write indices are ignored,
// out-of-range read indices return zero. Reset clears all bytes.
module rxbuf_bank #(
    parameter int NB = can_rxbuf_pkg::RXB_BYTES,
    parameter int DW = can_rxbuf_pkg::RXB_DATA_W,
    parameter int IW = can_rxbuf_pkg::RXB_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    logic [DW-1:0] mem [NB];
    logic          wr_in_range;
    logic          rd_in_range;

    assign wr_in_range = (wr_idx <= LAST);
    assign rd_in_range = (rd_idx <= LAST);

    // Byte storage: clear on reset, write one in-range byte per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                mem[i] <= '0;
            end
        end else if (we && wr_in_range) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read port: zero outside the bank
    always_comb begin
        rd_data = '0;
        if (rd_in_range) begin
            rd_data = mem[rd_idx];
        end
    end
endmodule

// File: rtl/rxbuf_ctrl.sv
// Module: ownership controller. Tracks which bank is the write bank,
// whether a frame is open, whether a message is parked in the write
// bank, the CPU message-valid flag and the sticky overrun flag.
// Assumes strobes are single-cycle pulses from the sequencer and CPU.
module rxbuf_ctrl
    import can_rxbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frm_start,
    input  logic frm_ok,
    input  logic frm_abort,
    input  logic flt_pass,
    input  logic byte_we,
    input  logic rel,
    input  logic ovr_clr,
    output logic wr_sel,
    output logic wr_go,
    output logic msg_valid,
    output logic overrun,
    output logic park_full
);
    logic        frame_open;
    logic        commit_req;
    logic        handover;
    commit_act_e act;

    assign commit_req = frm_ok && frame_open && flt_pass;
    assign handover   = park_full && !msg_valid;
    assign wr_go      = frame_open && flt_pass && byte_we && !park_full;

    // Commit decision from the current ownership state
    always_comb begin
        act = CM_NONE;
        if (commit_req) begin
            if (park_full)      act = CM_DROP;
            else if (msg_valid) act = CM_PARK;
            else                act = CM_SWAP;
        end
    end

    // Frame window: opened by start, closed by either end strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_open <= 1'b0;
        end else if (frm_start) begin
            frame_open <= 1'b1;
        end else if (frm_ok || frm_abort) begin
            frame_open <= 1'b0;
        end
    end

    // Bank ownership, parked message and message-valid handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel    <= 1'b0;
            msg_valid <= 1'b0;
            park_full <= 1'b0;
        end else begin
            if (handover) begin
                wr_sel    <= ~wr_sel;
                msg_valid <= 1'b1;
                park_full <= 1'b0;
            end else if (act == CM_SWAP) begin
                wr_sel    <= ~wr_sel;
                msg_valid <= 1'b1;
            end else begin
                if (act == CM_PARK) begin
                    park_full <= 1'b1;
                end
                if (rel && msg_valid) begin
                    msg_valid <= 1'b0;
                end
            end
        end
    end

    // Sticky overrun: a drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (act == CM_DROP) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rxbuf_rdmux.sv
// Module: selects the CPU-owned bank's read data. The CPU bank is the
// one that is not currently the write bank.
module rxbuf_rdmux #(
    parameter int DW = can_rxbuf_pkg::RXB_DATA_W
) (
    input  logic          wr_sel,
    input  logic [DW-1:0] bank0_data,
    input  logic [DW-1:0] bank1_data,
    output logic [DW-1:0] cpu_data
);
    // CPU side reads the bank opposite the write bank
    always_comb begin
        cpu_data = wr_sel ? bank0_data : bank1_data;
    end
endmodule

// File: rtl/can_rx_dualbuf.sv
// Module: top of the double-buffered CAN receive store. Two banks,
// an ownership controller and a CPU read selector. Assumes the acceptance
// filter level is valid whenever the sequencer writes or commits.
module can_rx_dualbuf
    import can_rxbuf_pkg::*;
#(
    parameter int NB = RXB_BYTES,
    parameter int DW = RXB_DATA_W,
    parameter int IW = RXB_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_sof,
    input  logic          rx_accept,
    input  logic          rx_byte_we,
    input  logic [IW-1:0] rx_byte_idx,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_eof_ok,
    input  logic          rx_abort,
    input  logic [IW-1:0] cpu_idx,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cpu_release,
    input  logic          cpu_ovr_clear,
    output logic          msg_valid,
    output logic          overrun
);
    logic          wr_sel;
    logic          wr_go;
    logic          park_full;
    logic [DW-1:0] bank_rd [RXB_BANKS];

    rxbuf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_start (rx_sof),
        .frm_ok    (rx_eof_ok),
        .frm_abort (rx_abort),
        .flt_pass  (rx_accept),
        .byte_we   (rx_byte_we),
        .rel       (cpu_release),
        .ovr_clr   (cpu_ovr_clear),
        .wr_sel    (wr_sel),
        .wr_go     (wr_go),
        .msg_valid (msg_valid),
        .overrun   (overrun),
        .park_full (park_full)
    );

    // One bank per role slot; write enable follows the write-bank select
    for (genvar g = 0; g < RXB_BANKS; g++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_go && (wr_sel == 1'(g));
        rxbuf_bank #(.NB(NB), .DW(DW), .IW(IW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we),
            .wr_idx  (rx_byte_idx),
            .wr_data (rx_byte),
            .rd_idx  (cpu_idx),
            .rd_data (bank_rd[g])
        );
    end

    rxbuf_rdmux #(.DW(DW)) u_rdmux (
        .wr_sel     (wr_sel),
        .bank0_data (bank_rd[0]),
        .bank1_data (bank_rd[1]),
        .cpu_data   (cpu_rdata)
    );
endmodule

// File: rtl/can_rx_dualbuf_chk.sv
// Module: property checker for can_rx_dualbuf, attached by bind.
// Observes ports and the parked-message state only.
module can_rx_dualbuf_chk #(
    parameter int NB = 10,
    parameter int DW = 8,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_eof_ok,
    input logic          rx_abort,
    input logic          cpu_release,
    input logic          cpu_ovr_clear,
    input logic [IW-1:0] cpu_idx,
    input logic [DW-1:0] cpu_rdata,
    input logic          msg_valid,
    input logic          overrun,
    input logic          park_full
);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    // R1: flags come out of reset cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && !overrun));

    // R2: message-valid only rises after a commit or a parked handover
    assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ($past(rx_eof_ok) || $past(park_full)));

    // R4: an abort with a free CPU and nothing parked never raises valid
    assert_abort_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_abort && !rx_eof_ok && !msg_valid && !park_full) |=> !msg_valid);

    // R5: valid is held while the CPU has not released
    assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !cpu_release) |=> msg_valid);

    // R6: release with nothing parked drops valid next cycle
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_release && msg_valid && !park_full) |=> !msg_valid);

    // R7: overrun is sticky until cleared
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cpu_ovr_clear) |=> overrun);

    // R8: clear without a concurrent end strobe clears overrun
    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ovr_clear && !rx_eof_ok) |=> !overrun);

    // R9: reads outside the bank return zero
    assert_read_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_idx > LAST) |-> (cpu_rdata == '0));
endmodule

bind can_rx_dualbuf can_rx_dualbuf_chk #(.NB(NB), .DW(DW), .IW(IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_eof_ok     (rx_eof_ok),
    .rx_abort      (rx_abort),
    .cpu_release   (cpu_release),
    .cpu_ovr_clear (cpu_ovr_clear),
    .cpu_idx       (cpu_idx),
    .cpu_rdata     (cpu_rdata),
    .msg_valid     (msg_valid),
    .overrun       (overrun),
    .park_full     (park_full)
);

// File: tb/sim_can_rx_dualbuf.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a behavioural model built from the requirements.
module sim_can_rx_dualbuf;
    localparam int CLK_PERIOD = 100;
    localparam int NB = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sof = 1'b0, rx_accept = 1'b0, rx_byte_we = 1'b0;
    logic [3:0] rx_byte_idx = '0;
    logic [7:0] rx_byte = '0;
    logic       rx_eof_ok = 1'b0, rx_abort = 1'b0;
    logic [3:0] cpu_idx = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_release = 1'b0, cpu_ovr_clear = 1'b0;
    logic       msg_valid, overrun;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    logic [7:0] mb [2][NB];
    bit m_sel, m_val, m_park, m_ovr, m_open;
    logic [7:0] fb [NB];

    can_rx_dualbuf u0 (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_accept(rx_accept),
        .rx_byte_we(rx_byte_we), .rx_byte_idx(rx_byte_idx), .rx_byte(rx_byte),
        .rx_eof_ok(rx_eof_ok), .rx_abort(rx_abort), .cpu_idx(cpu_idx),
        .cpu_rdata(cpu_rdata), .cpu_release(cpu_release),
        .cpu_ovr_clear(cpu_ovr_clear), .msg_valid(msg_valid), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < NB; i++) mb[b][i] = 8'h00;
        m_sel = 0; m_val = 0; m_park = 0; m_ovr = 0; m_open = 0;
    endtask

    // next state of the model from the inputs sampled at this edge
    task automatic model_update();
        bit commit, handover;
        if (m_open && rx_accept && rx_byte_we && rx_byte_idx < NB && !m_park)
            mb[m_sel][rx_byte_idx] = rx_byte;
        commit   = rx_eof_ok && m_open && rx_accept;
        handover = m_park && !m_val;
        if (commit && m_park) m_ovr = 1;
        else if (cpu_ovr_clear) m_ovr = 0;
        if (handover) begin
            m_sel = !m_sel; m_val = 1; m_park = 0;
        end else if (commit && !m_park && !m_val) begin
            m_sel = !m_sel; m_val = 1;
        end else begin
            if (commit && !m_park && m_val) m_park = 1;
            if (cpu_release && m_val) m_val = 0;
        end
        if (rx_sof) m_open = 1;
        else if (rx_eof_ok || rx_abort) m_open = 0;
    endtask

    // one clock: inputs already set at the falling edge
    task automatic step();
        @(posedge clk);
        if (rst_n) model_update(); else model_reset();
        @(negedge clk);
        rx_sof = 0; rx_byte_we = 0; rx_eof_ok = 0; rx_abort = 0;
        cpu_release = 0; cpu_ovr_clear = 0;
    endtask

    task automatic check_flags(input string tag);
        chk({tag, " msg_valid"}, {7'd0, msg_valid}, {7'd0, m_val});
        chk({tag, " overrun"}, {7'd0, overrun}, {7'd0, m_ovr});
    endtask

    task automatic check_reads(input string tag);
        for (int i = 0; i < 16; i++) begin
            cpu_idx = 4'(i);
            #2;
            chk({tag, " read"}, cpu_rdata, (i < NB) ? mb[!m_sel][i] : 8'h00);
        end
        cpu_idx = '0;
    endtask

    // kind: 0 good end, 1 abort
    task automatic send_frame(input bit acc, input int kind, input int n);
        rx_accept = acc;
        rx_sof = 1; step();
        for (int i = 0; i < n; i++) begin
            rx_byte_we = 1; rx_byte_idx = 4'(i); rx_byte = fb[i]; step();
        end
        if (kind == 0) rx_eof_ok = 1; else rx_abort = 1;
        step();
    endtask

    task automatic fill(input int base);
        for (int i = 0; i < NB; i++) fb[i] = 8'(base + i * 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        @(negedge clk);
        step(); step();
        rst_n = 1;
        // R1: reset state
        check_flags("R1");
        check_reads("R1");

        // R2: first accepted frame handed straight to the CPU
        fill(8'h10); send_frame(1, 0, NB);
        check_flags("R2"); check_reads("R2");

        // R3: rejected frame while CPU holds: no park, no change
        fill(8'h80); send_frame(0, 0, NB);
        check_flags("R3"); check_reads("R3");
        cpu_release = 1; step(); step();
        check_flags("R3"); check_reads("R3");

        // R4: aborted frame with CPU free: no swap
        fill(8'h30); send_frame(1, 1, NB);
        check_flags("R4"); check_reads("R4");

        // R10: writes outside a frame window are ignored
        rx_accept = 1;
        rx_byte_we = 1; rx_byte_idx = 4'd0; rx_byte = 8'hEE; step();
        rx_eof_ok = 1; step();
        check_flags("R10"); check_reads("R10");

        // R9: out-of-range write index, then commit
        fill(8'h50);
        rx_sof = 1; step();
        rx_byte_we = 1; rx_byte_idx = 4'd12; rx_byte = 8'hAB; step();
        rx_byte_we = 1; rx_byte_idx = 4'd3; rx_byte = 8'h5A; step();
        rx_eof_ok = 1; step();
        check_flags("R9"); check_reads("R9");

        // R5: commit while CPU holds parks the message
        fill(8'h60); send_frame(1, 0, NB);
        check_flags("R5"); check_reads("R5");

        // R7: third message with one parked is dropped
        fill(8'hA0); send_frame(1, 0, NB);
        check_flags("R7"); check_reads("R7");
        repeat (3) step();
        check_flags("R7");

        // R6: release, valid drops, then parked message appears
        cpu_release = 1; step();
        check_flags("R6");
        step();
        check_flags("R6"); check_reads("R6");

        // R8: clear overrun
        cpu_ovr_clear = 1; step();
        check_flags("R8");

        // random traffic
        for (int k = 0; k < 3000; k++) begin
            rx_sof      = ($urandom % 8) == 0;
            if (($urandom % 16) == 0) rx_accept = !rx_accept;
            rx_byte_we  = $urandom % 2;
            rx_byte_idx = 4'($urandom % 16);
            rx_byte     = 8'($urandom);
            rx_eof_ok   = ($urandom % 10) == 0;
            rx_abort    = ($urandom % 20) == 0;
            cpu_release = ($urandom % 8) == 0;
            cpu_ovr_clear = ($urandom % 20) == 0;
            step();
            check_flags("R5");
            cpu_idx = 4'($urandom % 16);
            #2;
            chk("R2 random read", cpu_rdata,
                (cpu_idx < NB) ? mb[!m_sel][cpu_idx] : 8'h00);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule